// File: doc/BRIEF.md
# Neighbour-Shared Lookup Table Memory

This block is the lookup table memory of one core in a ring of cores. It holds a word-addressed table with two independent access ports. The first port belongs to the local core alone and serves its table read and write operations with no arbitration. The second port is shared by two masters: the local streamer, which only reads, and the adjacent core in the ring, which may read or write. Across the ring, each core reaches the table of the core after it, and the last core reaches the first. That ring wiring sits outside this block, and this project covers one instance.

On the shared port, a fixed-priority arbiter always favours the neighbour over the streamer. Each master uses a valid/ready handshake. A streamer request that loses arbitration sees ready low. It keeps its request up and is served in the first cycle the neighbour is absent. An owner code tells which master was served in each cycle. The read data is steered back on a per-master response channel, and this channel has a valid flag. All reads complete one clock after the address is accepted.

Top module: `nbr_lut_ram`

## Requirements
- R1: After reset, both response valids are low, both read data outputs are zero, and the owner code is 0 when no port-B request is present.
- R2: A port-A access with `a_en` high updates `a_rdata` at the following clock edge with the word stored at `a_addr`. A port-A write stores `a_wdata`. While `a_en` is low, `a_rdata` keeps its last value.
- R3: The neighbour can write and read the table through port B. An accepted neighbour read raises `nb_rvalid` for one cycle after the next edge, with the addressed word on `nb_rdata`. An accepted neighbour write raises no `nb_rvalid`.
- R4: A streamer request with no neighbour request sees `str_ready` high in the same cycle. After the next edge it gets `str_rvalid` high and the addressed word on `str_rdata`.
- R5: When `nb_valid` and `str_valid` are both high, `nb_ready` is high, `str_ready` is low, and the owner code shows the neighbour.
- R6: A stalled streamer that keeps `str_valid` and `str_addr` steady is granted in the first cycle with no neighbour request. Its data for the held address then arrives on the next edge.
- R7: When port A and port B both write the same address in one cycle, the table keeps port A's data.
- R8: A read on either port returns the word as it was before any write made in the same cycle.
- R9: The owner code `b_owner` is 2'b00 when port B is idle, 2'b01 for the streamer and 2'b10 for the neighbour, and it is valid in the request cycle. At most one response valid is high at a time. The read data of a master whose valid is low reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_en | input | 1 | Port-A access enable |
| a_we | input | 1 | Port-A write (with a_en) |
| a_addr | input | 9 | Port-A word address |
| a_wdata | input | 32 | Port-A write data |
| a_rdata | output | 32 | Port-A read data, one cycle after access |
| str_valid | input | 1 | Streamer read request |
| str_ready | output | 1 | Streamer request accepted this cycle |
| str_addr | input | 9 | Streamer word address |
| str_rvalid | output | 1 | Streamer read data valid |
| str_rdata | output | 32 | Streamer read data, zero when not valid |
| nb_valid | input | 1 | Neighbour request |
| nb_ready | output | 1 | Neighbour request accepted this cycle |
| nb_we | input | 1 | Neighbour write (else read) |
| nb_addr | input | 9 | Neighbour word address |
| nb_wdata | input | 32 | Neighbour write data |
| nb_rvalid | output | 1 | Neighbour read data valid |
| nb_rdata | output | 32 | Neighbour read data, zero when not valid |
| b_owner | output | 2 | Port-B owner this cycle: 00 idle, 01 streamer, 10 neighbour |

## Verification
The handshake outputs `str_ready`, `nb_ready` and `b_owner` are combinational. The bench samples them one time unit after it drives the request, before the clock edge. Every read result (`a_rdata`, both response valids and their data) comes from a single register stage, so the bench samples it at the falling edge that follows the accepting rising edge, which is exactly one cycle later. Same-cycle cases are driven in a single cycle: collisions, read-during-write, and contention followed by release. The stored outcome is then read back through port A on the next cycle.

// File: rtl/nbr_lut_pkg.sv
package nbr_lut_pkg;

   // Port-B owner code, also driven out of the block
   typedef enum logic [1:0] {
      OWN_NONE = 2'b00,
      OWN_STR  = 2'b01,
      OWN_NBR  = 2'b10
   } b_owner_e;

   // Response channel indices
   localparam int CH_STR = 0;
   localparam int CH_NBR = 1;
   localparam int NUM_CH = 2;

endpackage

// File: rtl/nbr_lut_arb.sv
module nbr_lut_arb
   import nbr_lut_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              str_valid,
   input  logic [ADDR_W-1:0] str_addr,
   input  logic              nb_valid,
   input  logic              nb_we,
   input  logic [ADDR_W-1:0] nb_addr,
   input  logic [DATA_W-1:0] nb_wdata,
   output logic              str_ready,
   output logic              nb_ready,
   output b_owner_e          owner,
   output logic              b_en,
   output logic              b_we,
   output logic [ADDR_W-1:0] b_addr,
   output logic [DATA_W-1:0] b_wdata
);

   initial begin
      assert (ADDR_W >= 1) else $error("nbr_lut_arb: ADDR_W must be at least 1");
      assert (DATA_W >= 1) else $error("nbr_lut_arb: DATA_W must be at least 1");
   end

   // Fixed priority: the neighbour always beats the streamer
   always_comb begin
      owner = OWN_NONE;
      if (nb_valid)       owner = OWN_NBR;
      else if (str_valid) owner = OWN_STR;
   end

   assign nb_ready  = (owner == OWN_NBR);
   assign str_ready = (owner == OWN_STR);

   // Port-B command mux
   always_comb begin
      b_en    = 1'b0;
      b_we    = 1'b0;
      b_addr  = '0;
      b_wdata = '0;
      unique case (owner)
         OWN_NBR: begin
            b_en    = 1'b1;
            b_we    = nb_we;
            b_addr  = nb_addr;
            b_wdata = nb_wdata;
         end
         OWN_STR: begin
            b_en    = 1'b1;
            b_addr  = str_addr;
         end
         default: ;
      endcase
   end

   // R5
   nb_over_str_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nb_valid && str_valid) |-> (nb_ready && !str_ready));

endmodule

// File: rtl/nbr_lut_mem.sv
module nbr_lut_mem #(
   parameter int WORDS  = 512,
   parameter int DATA_W = 32,
   localparam int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);

   initial begin
      assert (WORDS >= 2 && (WORDS & (WORDS - 1)) == 0)
         else $error("nbr_lut_mem: WORDS must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [WORDS];

   // Port B write first, port A second: A wins a same-address collision
   always_ff @(posedge clk) begin
      if (b_en && b_we) mem[b_addr] <= b_wdata;
      if (a_en && a_we) mem[a_addr] <= a_wdata;
   end

   // Read-first registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         if (a_en) a_rdata <= mem[a_addr];
         if (b_en) b_rdata <= mem[b_addr];
      end
   end

   // R7
   a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && a_we && b_en && b_we && a_addr == b_addr)
      |=> (mem[$past(a_addr)] == $past(a_wdata)));

   // R2
   a_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_en |=> (a_rdata == $past(mem[a_addr])));

   // R2
   a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !a_en |=> $stable(a_rdata));

endmodule

// File: rtl/nbr_lut_rsp.sv
module nbr_lut_rsp
   import nbr_lut_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  b_owner_e          owner,
   input  logic              b_we,
   input  logic [DATA_W-1:0] b_rdata,
   output logic              str_rvalid,
   output logic [DATA_W-1:0] str_rdata,
   output logic              nb_rvalid,
   output logic [DATA_W-1:0] nb_rdata
);

   logic [NUM_CH-1:0] rd_sel;
   logic [NUM_CH-1:0] rv;
   logic [DATA_W-1:0] rd [NUM_CH];

   assign rd_sel[CH_STR] = (owner == OWN_STR);
   assign rd_sel[CH_NBR] = (owner == OWN_NBR) && !b_we;

   // One response register per master
   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) v_q <= 1'b0;
         else        v_q <= rd_sel[g];
      end
      assign rv[g] = v_q;
      assign rd[g] = v_q ? b_rdata : '0;
   end

   assign str_rvalid = rv[CH_STR];
   assign str_rdata  = rd[CH_STR];
   assign nb_rvalid  = rv[CH_NBR];
   assign nb_rdata   = rd[CH_NBR];

   // R4
   str_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_STR) |=> str_rvalid);

   // R3
   nb_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_NBR && b_we) |=> !nb_rvalid);

   // R9
   rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({str_rvalid, nb_rvalid}));

endmodule

// File: rtl/nbr_lut_ram.sv
module nbr_lut_ram
   import nbr_lut_pkg::*;
#(
   parameter int WORDS  = 512,
   parameter int DATA_W = 32,
   localparam int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              str_valid,
   output logic              str_ready,
   input  logic [ADDR_W-1:0] str_addr,
   output logic              str_rvalid,
   output logic [DATA_W-1:0] str_rdata,
   input  logic              nb_valid,
   output logic              nb_ready,
   input  logic              nb_we,
   input  logic [ADDR_W-1:0] nb_addr,
   input  logic [DATA_W-1:0] nb_wdata,
   output logic              nb_rvalid,
   output logic [DATA_W-1:0] nb_rdata,
   output logic [1:0]        b_owner
);

   b_owner_e          owner;
   logic              b_en;
   logic              b_we;
   logic [ADDR_W-1:0] b_addr;
   logic [DATA_W-1:0] b_wdata;
   logic [DATA_W-1:0] b_rdata;

   nbr_lut_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .str_valid (str_valid),
      .str_addr  (str_addr),
      .nb_valid  (nb_valid),
      .nb_we     (nb_we),
      .nb_addr   (nb_addr),
      .nb_wdata  (nb_wdata),
      .str_ready (str_ready),
      .nb_ready  (nb_ready),
      .owner     (owner),
      .b_en      (b_en),
      .b_we      (b_we),
      .b_addr    (b_addr),
      .b_wdata   (b_wdata)
   );

   nbr_lut_mem #(.WORDS(WORDS), .DATA_W(DATA_W)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_en    (a_en),
      .a_we    (a_we),
      .a_addr  (a_addr),
      .a_wdata (a_wdata),
      .a_rdata (a_rdata),
      .b_en    (b_en),
      .b_we    (b_we),
      .b_addr  (b_addr),
      .b_wdata (b_wdata),
      .b_rdata (b_rdata)
   );

   nbr_lut_rsp #(.DATA_W(DATA_W)) u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .owner      (owner),
      .b_we       (b_we),
      .b_rdata    (b_rdata),
      .str_rvalid (str_rvalid),
      .str_rdata  (str_rdata),
      .nb_rvalid  (nb_rvalid),
      .nb_rdata   (nb_rdata)
   );

   assign b_owner = owner;

   // R6
   stall_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (str_valid && !nb_valid) |-> str_ready);

   // R3
   nb_read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nb_valid && nb_ready && !nb_we) |=> nb_rvalid);

endmodule

// File: tb/nbr_lut_ram_bench.sv
module nbr_lut_ram_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        a_en, a_we;
   logic [8:0]  a_addr;
   logic [31:0] a_wdata, a_rdata;
   logic        str_valid, str_ready, str_rvalid;
   logic [8:0]  str_addr;
   logic [31:0] str_rdata;
   logic        nb_valid, nb_ready, nb_we, nb_rvalid;
   logic [8:0]  nb_addr;
   logic [31:0] nb_wdata, nb_rdata;
   logic [1:0]  b_owner;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   nbr_lut_ram u_nbr_lut_ram (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .str_valid(str_valid), .str_ready(str_ready), .str_addr(str_addr),
      .str_rvalid(str_rvalid), .str_rdata(str_rdata),
      .nb_valid(nb_valid), .nb_ready(nb_ready), .nb_we(nb_we), .nb_addr(nb_addr),
      .nb_wdata(nb_wdata), .nb_rvalid(nb_rvalid), .nb_rdata(nb_rdata),
      .b_owner(b_owner)
   );

   // Vector: {str_v, nb_v, nb_we, exp_str_ready, exp_nb_ready, exp_owner[1:0]}
   localparam logic [6:0] VEC [6] = '{
      7'b000_00_00,
      7'b100_10_01,
      7'b010_01_10,
      7'b011_01_10,
      7'b110_01_10,
      7'b111_01_10
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
      str_valid = 0; str_addr = '0;
      nb_valid = 0; nb_we = 0; nb_addr = '0; nb_wdata = '0;
   endtask

   // Let the rising edge take the inputs, then stop at the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic a_write(input logic [8:0] ad, input logic [31:0] d);
      idle(); a_en = 1; a_we = 1; a_addr = ad; a_wdata = d;
      tick();
   endtask

   task automatic a_read(input logic [8:0] ad);
      idle(); a_en = 1; a_addr = ad;
      tick();
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 str_rvalid", {31'b0, str_rvalid}, 0);
      chk("R1 nb_rvalid", {31'b0, nb_rvalid}, 0);
      chk("R1 a_rdata", a_rdata, 0);
      chk("R1 str_rdata", str_rdata, 0);
      chk("R1 nb_rdata", nb_rdata, 0);
      chk("R1 owner", {30'b0, b_owner}, 0);
      rst_n = 1;
      tick();

      // Table walk over port-B request patterns (R5, R9)
      for (int i = 0; i < 6; i++) begin
         idle();
         str_valid = VEC[i][6]; str_addr = 9'd5;
         nb_valid = VEC[i][5]; nb_we = VEC[i][4]; nb_addr = 9'd500; nb_wdata = 32'h0;
         #1;
         chk("R5 str_ready", {31'b0, str_ready}, {31'b0, VEC[i][3]});
         chk("R5 nb_ready", {31'b0, nb_ready}, {31'b0, VEC[i][2]});
         chk("R9 owner", {30'b0, b_owner}, {30'b0, VEC[i][1:0]});
         tick();
         chk("R4 str_rvalid", {31'b0, str_rvalid}, {31'b0, VEC[i][3]});
         chk("R3 nb_rvalid", {31'b0, nb_rvalid}, {31'b0, VEC[i][2] & ~VEC[i][4]});
      end

      // R2 port A write and read
      a_write(9'd5, 32'hA5A5_0005);
      a_write(9'd511, 32'h5111_0511);
      a_read(9'd5);
      chk("R2 a_rdata", a_rdata, 32'hA5A5_0005);
      idle(); a_addr = 9'd511; tick();
      chk("R2 a_rdata hold", a_rdata, 32'hA5A5_0005);

      // R3 neighbour write, then reads
      idle(); nb_valid = 1; nb_we = 1; nb_addr = 9'd7; nb_wdata = 32'h1234_5678;
      tick();
      chk("R3 no rvalid on write", {31'b0, nb_rvalid}, 0);
      idle(); nb_valid = 1; nb_addr = 9'd7; tick();
      chk("R3 nb_rvalid", {31'b0, nb_rvalid}, 1);
      chk("R3 nb_rdata", nb_rdata, 32'h1234_5678);
      idle(); nb_valid = 1; nb_addr = 9'd5; tick();
      chk("R3 nb reads port-A word", nb_rdata, 32'hA5A5_0005);
      a_read(9'd7);
      chk("R3 port A sees nb write", a_rdata, 32'h1234_5678);

      // R4 streamer alone
      idle(); str_valid = 1; str_addr = 9'd511; #1;
      chk("R4 str_ready", {31'b0, str_ready}, 1);
      tick();
      chk("R4 str_rvalid", {31'b0, str_rvalid}, 1);
      chk("R4 str_rdata", str_rdata, 32'h5111_0511);
      chk("R9 nb_rdata zero", nb_rdata, 0);

      // R5 contention, then R6 release of the held request
      idle(); str_valid = 1; str_addr = 9'd7; nb_valid = 1; nb_addr = 9'd5; #1;
      chk("R5 str stalled", {31'b0, str_ready}, 0);
      chk("R5 nb granted", {31'b0, nb_ready}, 1);
      chk("R9 owner nbr", {30'b0, b_owner}, 2);
      tick();
      chk("R5 nb_rdata", nb_rdata, 32'hA5A5_0005);
      chk("R9 str_rvalid low", {31'b0, str_rvalid}, 0);
      chk("R9 str_rdata zero", str_rdata, 0);
      nb_valid = 0; #1;
      chk("R6 held request granted", {31'b0, str_ready}, 1);
      tick();
      chk("R6 str_rvalid", {31'b0, str_rvalid}, 1);
      chk("R6 held data", str_rdata, 32'h1234_5678);

      // R7 same-address write collision
      idle(); a_en = 1; a_we = 1; a_addr = 9'd9; a_wdata = 32'hAAAA_0009;
      nb_valid = 1; nb_we = 1; nb_addr = 9'd9; nb_wdata = 32'hBBBB_0009;
      tick();
      a_read(9'd9);
      chk("R7 port A wins", a_rdata, 32'hAAAA_0009);

      // R8 read during write on the other port
      idle(); a_en = 1; a_we = 1; a_addr = 9'd9; a_wdata = 32'hCCCC_0009;
      nb_valid = 1; nb_addr = 9'd9;
      tick();
      chk("R8 nb old word", nb_rdata, 32'hAAAA_0009);
      chk("R8 a_rdata old word", a_rdata, 32'hAAAA_0009);
      a_read(9'd9);
      chk("R8 new word stored", a_rdata, 32'hCCCC_0009);

      idle();
      tick();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule